// File: doc/BRIEF.md
# Multiphase Counter Time-Interval Digitizer

The block measures the time between a start event and a stop event. It does not use one very fast counter. A bank of binary counters runs from a multiphase clock. Each counter follows one phase and one edge of that clock. The phases are spread evenly over half a clock period, so counting on both edges gives a sequence of edges with uniform spacing. While the measurement gate is open, every counter counts its own edges. The sum of all counters then behaves like the count of a single clock running at sixteen times the phase rate on both edges. With sixteen 400 MHz phases, one least significant bit of the sum is 78.125 ps.

A processor uses the block through a small register port on the system clock. It writes an arm bit, fires the start and stop events, and polls the status register until the done flag is set. It then reads the result. The gate is built directly from the asynchronous start and stop edges. After the gate closes, the block waits a fixed number of system clocks so that every counter has settled, and then adds the counts in one step. The result is held until the host clears the block or arms it again. If a counter wraps, an overflow flag is set and the result is marked invalid.

Top module: `mpc_tdc`

## Requirements
- R1: After reset, the status register (address 1) reads zero and the result register (address 2) reads zero.
- R2: Writing the control register (address 0) with bit 0 set while the block is idle or done does four things: it zeroes the counters, clears the result, sets busy (status bit 0) and clears done (status bit 1).
- R3: The result equals the number of 78.125 ps edge-grid points in the interval [start, stop). Moving the stop event by one phase step changes the result by exactly one LSB, and the result stays within ±1 LSB of the interval divided by 78.125 ps.
- R4: Each of the 2×NUM_PHASES counters counts edges of its own phase and edge polarity only while the gate is open. The gate opens on the first rising edge of start_i after arming and closes on the first rising edge of stop_i that follows it.
- R5: A stop_i rising edge that arrives while the block is armed but before start has no effect on the measurement.
- R6: A second start_i rising edge during an open measurement has no effect on the result.
- R7: start_i and stop_i edges that arrive while the block is not armed leave the result and the status unchanged.
- R8: SETTLE_CYCLES system clocks after the gate closes, three things happen: done is set, busy is cleared, and the summed result becomes readable at address 2. While the gate is open, status reads busy only.
- R9: If any counter wraps, the sticky overflow flag (status bit 2) is set. Valid (status bit 3) is done and not overflow.
- R10: Writing the control register with bit 1 set returns the block to idle. It clears all flags, the result and the counters.
- R11: A read strobe places the addressed register on rdata_o at the next clock edge. Writes to addresses 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the register port and control |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_clk_i | input | NUM_PHASES | Evenly shifted phase clocks |
| start_i | input | 1 | Start event, rising edge |
| stop_i | input | 1 | Stop event, rising edge |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 result |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |

## Verification
The bench sweeps the stop event one phase step at a time from two sub-step start offsets. A counter on the wrong edge polarity, a misplaced phase, or a lost gate re-registration would show up as a skipped or doubled LSB in the sweep. Early stops, repeated starts and events while not armed are fired on purpose. A gate that trusted any edge would either close at once, restart the count, or corrupt a held result. A long interval that wraps the counters must raise overflow and drop valid. If the sync path were not cleared on re-arm, the block would report done before any start.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  timeunit 1ps;
  timeprecision 1fs;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SETTLE,
    ST_DONE
  } tdc_state_e;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_RESULT = 2'd2;

  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/tdc_gate.sv
module tdc_gate (
  input  logic clr_ni,
  input  logic armed_i,
  input  logic start_i,
  input  logic stop_i,
  output logic gate_o,
  output logic closed_o
);
  timeunit 1ps;
  timeprecision 1fs;

  logic start_seen_q;
  logic stop_seen_q;

  // edges act directly as clocks to keep full timing resolution
  always_ff @(posedge start_i or negedge clr_ni) begin
    if (!clr_ni)      start_seen_q <= 1'b0;
    else if (armed_i) start_seen_q <= 1'b1;
  end

  always_ff @(posedge stop_i or negedge clr_ni) begin
    if (!clr_ni)           stop_seen_q <= 1'b0;
    else if (start_seen_q) stop_seen_q <= 1'b1;
  end

  assign gate_o   = start_seen_q & ~stop_seen_q;
  assign closed_o = stop_seen_q;

  always_comb begin
    if (clr_ni) AST_STOP_AFTER_START: assert (!(stop_seen_q && !start_seen_q)); // R5
  end
endmodule

// File: rtl/tdc_edge_counter.sv
module tdc_edge_counter #(
  parameter int CNT_W    = 18,
  parameter bit NEG_EDGE = 1'b0
) (
  input  logic             ph_clk_i,
  input  logic             rst_ni,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  timeunit 1ps;
  timeprecision 1fs;

  logic             clk_int;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  if (NEG_EDGE) begin : g_neg
    assign clk_int = ~ph_clk_i;
  end else begin : g_pos
    assign clk_int = ph_clk_i;
  end

  // gate re-registered in the local edge domain before use
  always_ff @(posedge clk_int or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      en_q <= gate_i;
      if (en_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) ovf_q <= 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_CNT_FROZEN: assert property (@(posedge clk_int) disable iff (!rst_ni)
    !en_q |=> $stable(cnt_q)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_int) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R9
endmodule

// File: rtl/mpc_tdc.sv
module mpc_tdc
  import tdc_pkg::*;
#(
  parameter int NUM_PHASES    = 16,
  parameter int CNT_W         = 18,
  parameter int SUM_W         = CNT_W + $clog2(2 * NUM_PHASES),
  parameter int SETTLE_CYCLES = 4,
  parameter int DATA_W        = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] phase_clk_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o
);
  timeunit 1ps;
  timeprecision 1fs;

  localparam int NUM_CNT  = 2 * NUM_PHASES;
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  tdc_state_e                     state_q;
  logic                           clr_q;
  logic                           clr_n;
  logic                           gate;
  logic                           closed;
  logic                           closed_s1_q, closed_s2_q;
  logic [SETTLE_W-1:0]            settle_q;
  logic [SUM_W-1:0]               result_q;
  logic [SUM_W-1:0]               cnt_sum;
  logic                           ovf_q;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_vec;
  logic [NUM_CNT-1:0]             ovf_vec;
  logic [DATA_W-1:0]              rdata_q;
  logic                           wr_ctrl, arm_req, clr_req, arm_acc;
  logic                           busy, done, valid;
  logic                           unused_w;

  assign unused_w = ^wdata_i[DATA_W-1:2];

  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign arm_req = wr_ctrl && wdata_i[CTRL_ARM_BIT];
  assign clr_req = wr_ctrl && wdata_i[CTRL_CLR_BIT];
  assign arm_acc = arm_req && !clr_req && (state_q == ST_IDLE || state_q == ST_DONE);

  assign clr_n = rst_ni & ~clr_q;

  tdc_gate u_gate (
    .clr_ni  (clr_n),
    .armed_i (state_q == ST_ARMED),
    .start_i (start_i),
    .stop_i  (stop_i),
    .gate_o  (gate),
    .closed_o(closed)
  );

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    for (genvar e = 0; e < 2; e++) begin : g_edge
      tdc_edge_counter #(
        .CNT_W   (CNT_W),
        .NEG_EDGE(e == 1)
      ) u_cnt (
        .ph_clk_i(phase_clk_i[p]),
        .rst_ni  (clr_n),
        .gate_i  (gate),
        .cnt_o   (cnt_vec[2*p+e]),
        .ovf_o   (ovf_vec[2*p+e])
      );
    end
  end

  always_comb begin
    cnt_sum = '0;
    for (int i = 0; i < NUM_CNT; i++) cnt_sum = cnt_sum + SUM_W'(cnt_vec[i]);
  end

  // gate-closed flag into the system domain; cleared with the counters
  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n) begin
      closed_s1_q <= 1'b0;
      closed_s2_q <= 1'b0;
    end else begin
      closed_s1_q <= closed;
      closed_s2_q <= closed_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      clr_q    <= 1'b0;
      settle_q <= '0;
      result_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      clr_q <= arm_acc | clr_req;
      if (clr_req) begin
        state_q  <= ST_IDLE;
        result_q <= '0;
        ovf_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE, ST_DONE: begin
            if (arm_acc) begin
              state_q  <= ST_ARMED;
              result_q <= '0;
              ovf_q    <= 1'b0;
            end
          end
          ST_ARMED: begin
            if (closed_s2_q) begin
              state_q  <= ST_SETTLE;
              settle_q <= '0;
            end
          end
          ST_SETTLE: begin
            if (settle_q == SETTLE_W'(SETTLE_CYCLES - 1)) begin
              state_q  <= ST_DONE;
              result_q <= cnt_sum;
              ovf_q    <= |ovf_vec;
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy  = (state_q == ST_ARMED) || (state_q == ST_SETTLE);
  assign done  = (state_q == ST_DONE);
  assign valid = done & ~ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      unique case (addr_i)
        REG_STATUS: rdata_q <= {{(DATA_W-4){1'b0}}, valid, ovf_q, done, busy};
        REG_RESULT: rdata_q <= {{(DATA_W-SUM_W){1'b0}}, result_q};
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  AST_CLR_ZEROES_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> (cnt_sum == '0)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !wr_ctrl) |=> $stable(result_q)); // R7
  AST_DONE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(state_q == ST_SETTLE)); // R8
  AST_ARM_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_acc |=> (busy && !done)); // R2
endmodule

// File: tb/mpc_tdc_tb_top.sv
module mpc_tdc_tb_top;
  timeunit 1ps;
  timeprecision 1fs;

  localparam int  NPH   = 16;
  localparam int  CW    = 8;
  localparam int  DW    = 32;
  localparam real STEP  = 78.125;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NPH-1:0] ph = '0;
  logic           start = 1'b0, stop = 1'b0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [1:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  typedef struct { int res; bit ovf; bit chk_res; bit step; string tag; } exp_t;
  typedef struct { int res; logic [3:0] st; } obs_t;
  exp_t exp_q[$];
  obs_t obs_q[$];

  mpc_tdc #(.NUM_PHASES(NPH), .CNT_W(CW), .SETTLE_CYCLES(4), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_clk_i(ph), .start_i(start), .stop_i(stop),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #2500 clk = ~clk;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    initial begin
      #(real'(k) * STEP);
      forever #1250 ph[k] = ~ph[k];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_done();
    logic [DW-1:0] s;
    repeat (60) begin
      reg_rd(2'd1, s);
      if (s[1]) break;
    end
  endtask

  // mode 0 plain, 1 early stop, 2 repeated start
  task automatic run_meas(input string tag, input int n, input int mode,
                          input real ofs, input bit ovf, input bit step);
    exp_t e;
    obs_t o;
    logic [DW-1:0] d;
    e.res = n; e.ovf = ovf; e.chk_res = !ovf; e.step = step; e.tag = tag;
    exp_q.push_back(e);
    reg_wr(2'd0, 32'h1);
    repeat (2) @(negedge clk);
    #(ofs);
    if (mode == 1) begin
      stop = 1'b1; #625; stop = 1'b0; #625;
    end
    start = 1'b1;
    if (mode == 2) begin
      #(3.0 * STEP); start = 1'b0; #(2.0 * STEP); start = 1'b1;
      #(real'(n - 5) * STEP);
    end else begin
      #(real'(n) * STEP);
    end
    stop = 1'b1;
    #2000; start = 1'b0; stop = 1'b0;
    wait_done();
    reg_rd(2'd1, d); o.st = d[3:0];
    reg_rd(2'd2, d); o.res = int'(d);
    obs_q.push_back(o);
  endtask

  // scoreboard monitor
  initial begin
    int prev = 0;
    forever begin
      exp_t e;
      obs_t o;
      wait (obs_q.size() > 0);
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk({e.tag, " status R8 R9"}, int'(o.st), e.ovf ? 4'b0110 : 4'b1010);
      if (e.chk_res) begin
        chk({e.tag, " result R3 R4"}, o.res, e.res);
        if (e.step) chk({e.tag, " one LSB per step R3"}, o.res - prev, 1);
        prev = o.res;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog R8: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    reg_rd(2'd1, d); chk("reset status R1", int'(d), 0);
    reg_rd(2'd2, d); chk("reset result R1", int'(d), 0);

    // arm alone, then clear
    reg_wr(2'd0, 32'h1);
    reg_rd(2'd1, d); chk("arm busy R2", int'(d), 1);
    reg_wr(2'd0, 32'h2);
    reg_rd(2'd1, d); chk("clear idle R10", int'(d), 0);

    for (int n = 8; n < 28; n++)
      run_meas("sweep ofs39", n, 0, 39.0, 1'b0, n != 8);
    for (int n = 8; n < 20; n++)
      run_meas("sweep ofs10", n, 0, 10.0, 1'b0, n != 8);

    run_meas("early stop R5", 17, 1, 39.0, 1'b0, 1'b0);
    run_meas("double start R6", 23, 2, 39.0, 1'b0, 1'b0);
    run_meas("long gate", 40, 0, 50.0, 1'b0, 1'b0);
    wait (obs_q.size() == 0);

    // not armed: events ignored, result held
    reg_rd(2'd2, held);
    @(negedge clk); #39; start = 1'b1; #3000; stop = 1'b1; #2000; start = 1'b0; stop = 1'b0;
    repeat (10) @(negedge clk);
    reg_rd(2'd2, d); chk("unarmed events result R7", int'(d), int'(held));
    reg_rd(2'd1, d); chk("unarmed events status R7", int'(d), 4'b1010);
    reg_wr(2'd2, 32'hfff);
    reg_wr(2'd1, 32'hf);
    reg_rd(2'd2, d); chk("write to result ignored R11", int'(d), int'(held));
    reg_rd(2'd1, d); chk("write to status ignored R11", int'(d), 4'b1010);

    // open gate shows busy only
    reg_wr(2'd0, 32'h1);
    repeat (2) @(negedge clk);
    #39; start = 1'b1;
    reg_rd(2'd1, d); chk("gate open busy R8", int'(d), 1);
    stop = 1'b1; #2000; start = 1'b0; stop = 1'b0;
    wait_done();
    reg_rd(2'd1, d); chk("gate closed done R8", int'(d), 4'b1010);
    reg_wr(2'd0, 32'h2);
    reg_rd(2'd1, d); chk("clear status R10", int'(d), 0);
    reg_rd(2'd2, d); chk("clear result R10", int'(d), 0);

    run_meas("overflow R9", 9000, 0, 39.0, 1'b1, 1'b0);
    wait (obs_q.size() == 0);
    run_meas("after overflow R2", 12, 0, 39.0, 1'b0, 1'b0);
    wait (obs_q.size() == 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule